// File: doc/BRIEF.md
# Dual-Bank Glitch-Free Clock Root

This block produces one root clock from up to eight free-running source clocks. It holds two complete configuration banks. Each bank names one source and a rate setting. A single select input decides which bank drives the output. Software changes the rate or the source by writing the bank that is not in use while the clock keeps running, and then flips the select input. The output leaves the old bank and joins the new one without any shortened high or low phase. While the output is disabled, software rewrites the live bank directly and leaves the select input as it is.

A build parameter picks the rate stage. In the divider build, each bank has a 4-bit field that holds the divide ratio minus one. In the fractional build, each bank has an M/N pair that yields M output pulses in every N source cycles. In both builds, every output high phase is exactly one high phase of the selected source, gated through on that source's low phase. The hand-over between banks uses a synchronizer in each bank's own clock domain. The old bank must finish releasing before the new one may start, so at most one bank drives the output at any time. A bank whose source is not toggling never starts. It keeps the output low, and the switch can move back to a working bank.

Top module: `clk_root_dual_bank`

## Requirements
- R1: While rst_n is low, and after reset until root_en is raised, root_clk stays low with no pulses.
- R2: While root_en is low, root_clk stays low with no pulses.
- R3: With root_en high, bank_sel value 0 selects bank 0 and value 1 selects bank 1. A bank's 3-bit source field value k routes src_clks[k].
- R4: Divider build (USE_MN=0): a divide field value d gives exactly one output high pulse per d+1 cycles of the selected source. Each high pulse equals one source high phase.
- R5: Divider build: a divide field value of 0 passes the selected source at full rate.
- R6: Fractional build (USE_MN=1): with N nonzero and M not above N, the output carries M pulses in every N source cycles. With N equal to 0, the counter is bypassed and the source passes at full rate. Each pulse equals one source high phase.
- R7: Flipping bank_sel while the output runs produces no high pulse shorter than the smaller of the two sources' high phases. Once the switch settles, the output runs at the new bank's rate.
- R8: Rewriting any field of the idle bank while the other bank is live leaves the output unchanged.
- R9: At most one bank drives root_clk. No high pulse is longer than the longer of the two sources' high phases.
- R10: Selecting a bank whose source does not toggle holds root_clk low. Flipping back to a bank with a running source resumes the output at that bank's rate.
- R11: When root_en falls during a high pulse, that pulse completes at full width. No pulse follows once the release has passed through the live bank's synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all clock domains |
| src_clks | input | 8 | Candidate source clocks, index = source code |
| root_en | input | 1 | Output enable |
| bank_sel | input | 1 | Active bank index |
| b0_src | input | 3 | Bank 0 source code |
| b0_div | input | DIV_W | Bank 0 divide ratio minus one (divider build) |
| b0_m | input | MN_W | Bank 0 M value (fractional build) |
| b0_n | input | MN_W | Bank 0 N value, 0 bypasses (fractional build) |
| b1_src | input | 3 | Bank 1 source code |
| b1_div | input | DIV_W | Bank 1 divide ratio minus one (divider build) |
| b1_m | input | MN_W | Bank 1 M value (fractional build) |
| b1_n | input | MN_W | Bank 1 N value, 0 bypasses (fractional build) |
| root_clk | output | 1 | Root clock output |

## Verification
The assertions assume three things about the inputs. Software never rewrites the live bank's fields while that bank is running. M never exceeds N. bank_sel does not flip again until the previous hand-over has settled. The exclusivity and counter-range checks depend on all three. The stimulus respects these limits. It writes only the idle bank, or writes the live bank only after the enable has dropped and the bank has released. It waits several hundred nanoseconds after each flip before changing anything further. It uses only M/N pairs with M not above N.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

  localparam int SRC_SEL_W = 3;
  localparam int SRC_COUNT = 1 << SRC_SEL_W;

  // next value of a divide counter that wraps after reaching 'last'
  function automatic logic [15:0] div_advance(logic [15:0] cnt, logic [15:0] last);
    return (cnt >= last) ? 16'd0 : cnt + 16'd1;
  endfunction

  // a fractional step fires when the accumulator would reach n
  function automatic logic mn_fires(logic [16:0] acc, logic [15:0] m, logic [15:0] n);
    return (n == 16'd0) || ((acc + {1'b0, m}) >= {1'b0, n});
  endfunction

  function automatic logic [16:0] mn_advance(logic [16:0] acc, logic [15:0] m, logic [15:0] n);
    logic [16:0] sum;
    sum = acc + {1'b0, m};
    if (n == 16'd0) return 17'd0;
    if (sum >= {1'b0, n}) return sum - {1'b0, n};
    return sum;
  endfunction

endpackage

// File: rtl/cr_src_pick.sv
module cr_src_pick #(
  parameter int NUM   = 8,
  parameter int SEL_W = 3
) (
  input  logic [NUM-1:0]   src_clks,
  input  logic [SEL_W-1:0] sel,
  output logic             bank_clk
);
  assign bank_clk = src_clks[sel];
endmodule

// File: rtl/cr_rate_gen.sv
module cr_rate_gen #(
  parameter bit USE_MN = 1'b0,
  parameter int DIV_W  = 4,
  parameter int MN_W   = 8
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             live,
  input  logic [DIV_W-1:0] div,
  input  logic [MN_W-1:0]  m,
  input  logic [MN_W-1:0]  n,
  output logic             tick
);
  localparam int AW = MN_W + 1;

  generate
    if (USE_MN) begin : g_mn
      logic [AW-1:0] acc_q;
      logic          unused_div;
      assign unused_div = ^div;

      always_comb tick = clkroot_pkg::mn_fires(17'(acc_q), 16'(m), 16'(n));

      always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n)     acc_q <= '0;
        else if (!live) acc_q <= '0;
        else            acc_q <= AW'(clkroot_pkg::mn_advance(17'(acc_q), 16'(m), 16'(n)));
      end

      // R6: accumulator stays below N while the bank runs a legal ratio
      assert_mn_acc_range_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        (live && (n != '0) && (m <= n)) |-> (acc_q < {1'b0, n}));
    end else begin : g_div
      logic [DIV_W-1:0] cnt_q;
      logic             unused_mn;
      assign unused_mn = ^{m, n};

      always_comb tick = (cnt_q == '0);

      always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (!live) cnt_q <= '0;
        else            cnt_q <= DIV_W'(clkroot_pkg::div_advance(16'(cnt_q), 16'(div)));
      end

      // R4: divide counter never passes the programmed ratio
      assert_div_count_range_R4: assert property (@(posedge bclk) disable iff (!rst_n)
        live |-> (cnt_q <= div));
    end
  endgenerate
endmodule

// File: rtl/cr_bank_gate.sv
module cr_bank_gate (
  input  logic bclk,
  input  logic rst_n,
  input  logic want,
  input  logic other_run,
  input  logic tick,
  output logic live,
  output logic run,
  output logic gclk
);
  logic sync1_q, sync2_q, gate_q;

  // two-flop request synchronizer in this bank's clock domain
  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= want & ~other_run;
      sync2_q <= sync1_q;
    end
  end

  // low-phase stage: changes only while the source is low
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      run    <= sync2_q;
      gate_q <= sync2_q & tick;
    end
  end

  assign live = sync2_q;
  assign gclk = bclk & gate_q;

  // R11: a request held low for two edges has released the bank
  assert_release_on_drop_R11: assert property (@(posedge bclk) disable iff (!rst_n)
    (!want && !$past(want)) |=> !run);
endmodule

// File: rtl/clk_root_dual_bank.sv
module clk_root_dual_bank
  import clkroot_pkg::*;
#(
  parameter bit USE_MN = 1'b0,
  parameter int DIV_W  = 4,
  parameter int MN_W   = 8
) (
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] src_clks,
  input  logic                 root_en,
  input  logic                 bank_sel,
  input  logic [SRC_SEL_W-1:0] b0_src,
  input  logic [DIV_W-1:0]     b0_div,
  input  logic [MN_W-1:0]      b0_m,
  input  logic [MN_W-1:0]      b0_n,
  input  logic [SRC_SEL_W-1:0] b1_src,
  input  logic [DIV_W-1:0]     b1_div,
  input  logic [MN_W-1:0]      b1_m,
  input  logic [MN_W-1:0]      b1_n,
  output logic                 root_clk
);
  localparam int NB = 2;

  logic [SRC_SEL_W-1:0] cfg_src [NB];
  logic [DIV_W-1:0]     cfg_div [NB];
  logic [MN_W-1:0]      cfg_m   [NB];
  logic [MN_W-1:0]      cfg_n   [NB];

  assign cfg_src[0] = b0_src;  assign cfg_src[1] = b1_src;
  assign cfg_div[0] = b0_div;  assign cfg_div[1] = b1_div;
  assign cfg_m[0]   = b0_m;    assign cfg_m[1]   = b1_m;
  assign cfg_n[0]   = b0_n;    assign cfg_n[1]   = b1_n;

  // named per-bank events for the checks below
  logic [NB-1:0] bank_clk, bank_live, bank_run, bank_gclk;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      logic want, tick;
      assign want = root_en & (bank_sel == (b != 0));

      cr_src_pick #(.NUM(SRC_COUNT), .SEL_W(SRC_SEL_W)) u_pick (
        .src_clks (src_clks),
        .sel      (cfg_src[b]),
        .bank_clk (bank_clk[b])
      );

      cr_rate_gen #(.USE_MN(USE_MN), .DIV_W(DIV_W), .MN_W(MN_W)) u_rate (
        .bclk  (bank_clk[b]),
        .rst_n (rst_n),
        .live  (bank_live[b]),
        .div   (cfg_div[b]),
        .m     (cfg_m[b]),
        .n     (cfg_n[b]),
        .tick  (tick)
      );

      cr_bank_gate u_gate (
        .bclk      (bank_clk[b]),
        .rst_n     (rst_n),
        .want      (want),
        .other_run (bank_run[NB-1-b]),
        .tick      (tick),
        .live      (bank_live[b]),
        .run       (bank_run[b]),
        .gclk      (bank_gclk[b])
      );

      // R8: only the idle bank may be rewritten; a running bank keeps its fields
      assert_live_cfg_stable_R8: assert property (@(posedge bank_clk[b]) disable iff (!rst_n)
        (bank_live[b] && $past(bank_live[b])) |->
          $stable({cfg_src[b], cfg_div[b], cfg_m[b], cfg_n[b]}));
    end
  endgenerate

  assign root_clk = |bank_gclk;

  // R9: the two banks never run at the same time
  always_comb begin
    if (rst_n) begin
      assert_bank_exclusive_R9: assert (!(bank_run[0] && bank_run[1]));
    end
  end
endmodule

// File: tb/test_clk_root_dual_bank.sv
`timescale 1ns/1ps

module pulse_meter (input logic sig);
  int      count;
  bit      have, hi;
  realtime t_up, t_prev, w, p;
  realtime min_hi, max_hi, min_per, max_per;

  task automatic clear();
    count = 0; have = 0; hi = 0;
    min_hi = 1.0e9; max_hi = 0.0; min_per = 1.0e9; max_per = 0.0;
  endtask

  initial clear();

  always @(posedge sig) begin
    if (have) begin
      p = $realtime - t_prev;
      if (p < min_per) min_per = p;
      if (p > max_per) max_per = p;
    end
    have = 1; hi = 1; t_prev = $realtime; t_up = $realtime;
    count++;
  end

  always @(negedge sig) begin
    if (hi) begin
      w = $realtime - t_up;
      if (w < min_hi) min_hi = w;
      if (w > max_hi) max_hi = w;
      hi = 0;
    end
  end
endmodule

module test_clk_root_dual_bank;
  logic clk = 0, s1 = 0, s2 = 0, s3 = 0, s4 = 0, s5 = 0, s6 = 0;
  always #10 clk = ~clk;   // source 0: 20 ns
  always #4  s1  = ~s1;    // source 1: 8 ns
  always #6  s2  = ~s2;    // source 2: 12 ns
  always #15 s3  = ~s3;    // source 3: 30 ns
  always #3  s4  = ~s4;    // source 4: 6 ns
  always #8  s5  = ~s5;    // source 5: 16 ns
  always #5  s6  = ~s6;    // source 6: 10 ns
  logic [7:0] srcs;
  assign srcs = {1'b0, s6, s5, s4, s3, s2, s1, clk};  // source 7 never toggles

  logic rst_n = 0;
  logic en_a = 0, sel_a = 0;
  logic [2:0] a0_src = 3'd1, a1_src = 3'd2;
  logic [3:0] a0_div = 4'd0, a1_div = 4'd2;
  logic root_a;

  logic en_b = 0, sel_b = 0;
  logic [2:0] f0_src = 3'd4, f1_src = 3'd6;
  logic [3:0] f0_m = 4'd3, f0_n = 4'd8, f1_m = 4'd0, f1_n = 4'd0;
  logic root_b;

  clk_root_dual_bank #(.USE_MN(1'b0), .DIV_W(4), .MN_W(8)) i_clk_root_dual_bank (
    .rst_n(rst_n), .src_clks(srcs), .root_en(en_a), .bank_sel(sel_a),
    .b0_src(a0_src), .b0_div(a0_div), .b0_m(8'd0), .b0_n(8'd0),
    .b1_src(a1_src), .b1_div(a1_div), .b1_m(8'd0), .b1_n(8'd0),
    .root_clk(root_a));

  clk_root_dual_bank #(.USE_MN(1'b1), .DIV_W(4), .MN_W(4)) i_clk_root_dual_bank_mn (
    .rst_n(rst_n), .src_clks(srcs), .root_en(en_b), .bank_sel(sel_b),
    .b0_src(f0_src), .b0_div(4'd0), .b0_m(f0_m), .b0_n(f0_n),
    .b1_src(f1_src), .b1_div(4'd0), .b1_m(f1_m), .b1_n(f1_n),
    .root_clk(root_b));

  pulse_meter m_a (.sig(root_a));
  pulse_meter m_b (.sig(root_b));

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk_int(string req, string what, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic chk_time(string req, string what, realtime act, realtime exp);
    total++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      bad++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_atleast(string req, string what, realtime act, realtime lim);
    total++;
    if (act < lim - 0.01) begin
      bad++;
      $display("FAIL %s %s: actual=%0.3f expected>=%0.3f", req, what, act, lim);
    end
  endtask

  task automatic chk_atmost(string req, string what, realtime act, realtime lim);
    total++;
    if (act > lim + 0.01) begin
      bad++;
      $display("FAIL %s %s: actual=%0.3f expected<=%0.3f", req, what, act, lim);
    end
  endtask

  // R1, R2: quiet during reset and while disabled
  task automatic t_reset();
    #100;
    chk_int("R1", "root low in reset", int'(root_a), 0, 0);
    chk_int("R1", "pulses in reset", m_a.count, 0, 0);
    rst_n = 1;
    m_a.clear();
    #400;
    chk_int("R2", "pulses while disabled", m_a.count, 0, 0);
    chk_int("R1", "fractional build quiet", m_b.count, 0, 0);
  endtask

  // R3, R5: bank 0 on source 1 at full rate
  task automatic t_full_rate();
    en_a = 1;
    #200;
    m_a.clear();
    #400;
    chk_time("R5", "period", m_a.min_per, 8.0);
    chk_time("R5", "period max", m_a.max_per, 8.0);
    chk_time("R3", "high width source 1", m_a.max_hi, 4.0);
    chk_int("R5", "pulse count", m_a.count, 49, 51);
  endtask

  // R7, R9, R4: flip to bank 1 (source 2, ratio 3)
  task automatic t_switch();
    m_a.clear();
    sel_a = 1;
    #400;
    chk_atleast("R7", "no runt across flip", m_a.min_hi, 4.0);
    chk_atmost("R9", "no merged pulse", m_a.max_hi, 6.0);
    m_a.clear();
    #720;
    chk_time("R4", "period ratio 3", m_a.min_per, 36.0);
    chk_time("R4", "period ratio 3 max", m_a.max_per, 36.0);
    chk_time("R4", "high width", m_a.min_hi, 6.0);
    chk_int("R4", "pulse count", m_a.count, 19, 21);
  endtask

  // R8: rewrite idle bank 0 repeatedly while bank 1 runs
  task automatic t_idle_rewrite();
    m_a.clear();
    for (int i = 0; i < 6; i++) begin
      a0_src = 3'((i * 5 + 2) % 8);
      a0_div = 4'(i * 3);
      #60;
    end
    a0_src = 3'd3;
    a0_div = 4'd1;
    #60;
    chk_time("R8", "period undisturbed", m_a.min_per, 36.0);
    chk_time("R8", "period undisturbed max", m_a.max_per, 36.0);
    chk_time("R8", "width undisturbed", m_a.min_hi, 6.0);
  endtask

  // R3, R4: back to bank 0, now source 3 ratio 2
  task automatic t_source3();
    sel_a = 0;
    #400;
    m_a.clear();
    #1200;
    chk_time("R3", "period source 3", m_a.min_per, 60.0);
    chk_time("R3", "high width source 3", m_a.max_hi, 15.0);
    chk_int("R4", "pulse count", m_a.count, 19, 21);
  endtask

  // R10: dead source, then recovery
  task automatic t_dead();
    a1_src = 3'd7;
    a1_div = 4'd0;
    #40;
    sel_a = 1;
    #400;
    m_a.clear();
    #600;
    chk_int("R10", "pulses on dead source", m_a.count, 0, 0);
    chk_int("R10", "root low on dead source", int'(root_a), 0, 0);
    sel_a = 0;
    #400;
    m_a.clear();
    #1200;
    chk_time("R10", "period after recovery", m_a.min_per, 60.0);
    chk_int("R10", "pulse count after recovery", m_a.count, 19, 21);
  endtask

  // R11, R2: disable in mid pulse
  task automatic t_disable();
    m_a.clear();
    @(posedge root_a);
    #5;
    en_a = 0;
    #400;
    chk_time("R11", "pulse completes", m_a.min_hi, 15.0);
    chk_time("R11", "no stretched pulse", m_a.max_hi, 15.0);
    chk_int("R11", "pulses after drop", m_a.count, 1, 2);
    m_a.clear();
    #400;
    chk_int("R2", "quiet after disable", m_a.count, 0, 0);
    chk_int("R2", "root low after disable", int'(root_a), 0, 0);
  endtask

  // R6: fractional build, 3 in 8 on source 4, then bypass on source 6
  task automatic t_fraction();
    en_b = 1;
    #300;
    m_b.clear();
    #480;
    chk_int("R6", "3 of 8 pulse count", m_b.count, 29, 31);
    chk_time("R6", "pulse width source 4", m_b.min_hi, 3.0);
    chk_time("R6", "pulse width max", m_b.max_hi, 3.0);
    sel_b = 1;
    #300;
    m_b.clear();
    #500;
    chk_time("R6", "bypass period", m_b.min_per, 10.0);
    chk_time("R6", "bypass period max", m_b.max_per, 10.0);
    chk_int("R6", "bypass count", m_b.count, 49, 51);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_full_rate();
    t_switch();
    t_idle_rewrite();
    t_source3();
    t_dead();
    t_disable();
    t_fraction();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule